// File: doc/BRIEF.md
# Signed Decimal Accumulator Adder/Subtractor

This combinational unit adds or subtracts two signed decimal words. Each word carries three binary-coded decimal digits for its magnitude and a one-bit sign digit. A processor datapath gives it the accumulator value, a memory operand and an operation select. It returns the signed result in sign-magnitude form and an overflow flag.

Inside the unit, each operand that is negative, or that becomes negative through subtraction, is turned into its nines' complement and given a sign digit of 1. The two words are summed digit by digit with decimal carry. Correction ones turn the nines' complement sums into exact ten's complement values. The sign digit sums modulo two. A negative sum is complemented back into a magnitude. There are no registers: the outputs follow the inputs in the same cycle.

Top module: `bcd_acc_alu`

## Requirements
- R1: With both effective operands non-negative and a true sum of at most 999, the result is that sum with sign 0 and `ovf_o` low.
- R2: With `sub_i` high, the result is a minus b. For example, 500 minus 155 gives +345.
- R3: A sign bit of 1 marks a negative operand. When the effective signs differ, the result is the signed difference, with sign 1 exactly when the negative magnitude is the larger.
- R4: A zero result is always presented as sign 0 and magnitude 000. This holds when the inputs include negative zero.
- R5: Every result digit is a valid BCD digit (0 to 9). A digit sum above 9 carries one into the next digit, so 199 plus 1 gives 200.
- R6: `ovf_o` is high exactly when the true result lies outside -999..+999, and this includes -1000. While `ovf_o` is high, the result fields are not specified.
- R7: `sub_i` flips the sign of b before the addition, so a minus (-b) equals a plus b.
- R8: When one effective operand is negative and the other is not (a negative zero counts as non-negative), `ovf_o` stays low.
- R9: Magnitude digit k occupies bits [4k+3:4k], with digit 0 the least significant. The sign is a separate bit where 0 means positive and 1 means negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_sign_i | input | 1 | Sign of the accumulator operand (1 = negative) |
| a_mag_i | input | 12 | BCD magnitude of the accumulator operand |
| b_sign_i | input | 1 | Sign of the memory operand (1 = negative) |
| b_mag_i | input | 12 | BCD magnitude of the memory operand |
| sub_i | input | 1 | 1 selects a minus b, 0 selects a plus b |
| res_sign_o | output | 1 | Sign of the result |
| res_mag_o | output | 12 | BCD magnitude of the result |
| ovf_o | output | 1 | True result magnitude exceeds 999 |

## Verification
The assertions assume that every input digit is a legal BCD value from 0 to 9. They skip evaluation whenever any input nibble is 10 or higher, because the result for such input is not specified. The stimulus keeps to this assumption: all operands are built from integers between 0 and 999, split into decimal digits. Negative zero and the ±999 limits are driven on purpose, since they are the inputs closest to an illegal or overflowing pattern.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_pkg::*;
(
  input  bcd_digit_t a_i,
  input  bcd_digit_t b_i,
  input  logic       ci_i,
  output bcd_digit_t s_o,
  output logic       co_o
);
  logic [DIGIT_W:0] raw;

  always_comb begin
    raw = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, ci_i};
    if (raw > {1'b0, DIGIT_MAX}) begin
      s_o  = DIGIT_W'(raw - (DIGIT_W+1)'(10));
      co_o = 1'b1;
    end else begin
      s_o  = raw[DIGIT_W-1:0];
      co_o = 1'b0;
    end
  end

  // R5: legal digits in give a legal digit out
  always_comb begin
    if (a_i <= DIGIT_MAX && b_i <= DIGIT_MAX)
      a_r5_digit_bcd: assert (s_o <= DIGIT_MAX);
  end
endmodule

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_pkg::*;
#(
  parameter int unsigned NDIG = 3,
  localparam int unsigned MAG_W = NDIG * DIGIT_W
) (
  input  logic             en_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0] mag_o
);
  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    bcd_digit_t d;
    assign d = mag_i[k*DIGIT_W +: DIGIT_W];
    assign mag_o[k*DIGIT_W +: DIGIT_W] = en_i ? DIGIT_W'(DIGIT_MAX - d) : d;
  end
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple
  import bcd_pkg::*;
#(
  parameter int unsigned NDIG = 3,
  localparam int unsigned MAG_W = NDIG * DIGIT_W
) (
  input  logic [MAG_W-1:0] a_i,
  input  logic [MAG_W-1:0] b_i,
  input  logic             ci_i,
  output logic [MAG_W-1:0] s_o,
  output logic             co_o
);
  logic [NDIG:0] carry;
  assign carry[0] = ci_i;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    bcd_digit_add u_add (
      .a_i  (a_i[k*DIGIT_W +: DIGIT_W]),
      .b_i  (b_i[k*DIGIT_W +: DIGIT_W]),
      .ci_i (carry[k]),
      .s_o  (s_o[k*DIGIT_W +: DIGIT_W]),
      .co_o (carry[k+1])
    );
  end

  assign co_o = carry[NDIG];
endmodule

// File: rtl/bcd_acc_alu.sv
module bcd_acc_alu
  import bcd_pkg::*;
#(
  parameter int unsigned NDIG = 3,
  localparam int unsigned MAG_W = NDIG * DIGIT_W
) (
  input  logic             a_sign_i,
  input  logic [MAG_W-1:0] a_mag_i,
  input  logic             b_sign_i,
  input  logic [MAG_W-1:0] b_mag_i,
  input  logic             sub_i,
  output logic             res_sign_o,
  output logic [MAG_W-1:0] res_mag_o,
  output logic             ovf_o
);
  logic             neg_a, neg_b;
  logic [MAG_W-1:0] a_cpl, b_cpl, sum1, sum2, sum_cpl, mag;
  logic             co1, co2, co_back, sum_sign;
  logic             live_a, live_b;

  assign neg_a = a_sign_i;
  assign neg_b = b_sign_i ^ sub_i;

  bcd_nines #(.NDIG(NDIG)) u_cpl_a (.en_i(neg_a), .mag_i(a_mag_i), .mag_o(a_cpl));
  bcd_nines #(.NDIG(NDIG)) u_cpl_b (.en_i(neg_b), .mag_i(b_mag_i), .mag_o(b_cpl));

  // correction one for operand a rides the carry-in
  bcd_ripple #(.NDIG(NDIG)) u_sum (
    .a_i(a_cpl), .b_i(b_cpl), .ci_i(neg_a), .s_o(sum1), .co_o(co1)
  );
  // correction one for operand b in a separate pass (keeps digit sum below 20)
  bcd_ripple #(.NDIG(NDIG)) u_fix (
    .a_i(sum1), .b_i('0), .ci_i(neg_b), .s_o(sum2), .co_o(co2)
  );

  // sign digit is one bit wide: sums modulo two
  assign sum_sign = neg_a ^ neg_b ^ co1 ^ co2;

  bcd_nines #(.NDIG(NDIG)) u_cpl_r (.en_i(sum_sign), .mag_i(sum2), .mag_o(sum_cpl));
  bcd_ripple #(.NDIG(NDIG)) u_back (
    .a_i(sum_cpl), .b_i('0), .ci_i(sum_sign), .s_o(mag), .co_o(co_back)
  );

  assign res_mag_o  = mag;
  assign res_sign_o = sum_sign & (|mag);

  // negative zero counts as non-negative for overflow
  assign live_a = neg_a & (|a_mag_i);
  assign live_b = neg_b & (|b_mag_i);
  assign ovf_o  = (~live_a & ~live_b & sum_sign)
                | ( live_a &  live_b & (~sum_sign | co_back));

  function automatic logic all_bcd(input logic [MAG_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < int'(NDIG); k++)
      if (v[k*DIGIT_W +: DIGIT_W] > DIGIT_MAX) ok = 1'b0;
    return ok;
  endfunction

  logic in_ok;
  assign in_ok = all_bcd(a_mag_i) && all_bcd(b_mag_i);

  always_comb begin
    if (in_ok) begin
      a_r4_no_neg_zero:  assert (!res_sign_o || (|res_mag_o));
      a_r8_mixed_no_ovf: assert ((live_a == live_b) || !ovf_o);
      a_r1_pos_sign:     assert (live_a || live_b || ovf_o || !res_sign_o);
      a_r3_neg_sign:     assert (!(live_a && live_b) || ovf_o || res_sign_o);
      a_r5_result_bcd:   assert (all_bcd(res_mag_o));
    end
  end
endmodule

// File: tb/bcd_acc_alu_test.sv
module bcd_acc_alu_test;
  localparam int NDIG = 3;
  localparam int MAG_W = 4 * NDIG;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic             a_sign, b_sign, sub;
  logic [MAG_W-1:0] a_mag, b_mag;
  logic             res_sign, ovf;
  logic [MAG_W-1:0] res_mag;

  bcd_acc_alu #(.NDIG(NDIG)) uut (
    .a_sign_i(a_sign), .a_mag_i(a_mag), .b_sign_i(b_sign), .b_mag_i(b_mag),
    .sub_i(sub), .res_sign_o(res_sign), .res_mag_o(res_mag), .ovf_o(ovf)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  function automatic logic [MAG_W-1:0] to_bcd(input int m);
    logic [MAG_W-1:0] v;
    int r;
    v = '0;
    r = m;
    for (int k = 0; k < NDIG; k++) begin
      v[k*4 +: 4] = 4'(r % 10);
      r = r / 10;
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive after a rising edge, compare at the following falling edge
  task automatic run(input string req, input int sa, input int ma,
                     input int sb, input int mb, input int s);
    int va, vb, t, mt;
    bit exp_ovf;
    @(posedge clk);
    #1;
    a_sign = 1'(sa); a_mag = to_bcd(ma);
    b_sign = 1'(sb); b_mag = to_bcd(mb);
    sub = 1'(s);
    va = sa != 0 ? -ma : ma;
    vb = ((sb != 0) ^ (s != 0)) ? -mb : mb;
    t = va + vb;
    exp_ovf = (t > 999) || (t < -999);
    mt = t < 0 ? -t : t;
    @(negedge clk);
    chk({req, " ovf"}, 32'(ovf), 32'(exp_ovf));
    if (!exp_ovf)
      chk({req, " result"}, {19'd0, res_sign, res_mag}, {19'd0, 1'(t < 0), to_bcd(mt)});
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    a_sign = 0; b_sign = 0; sub = 0; a_mag = '0; b_mag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 idle zero", {19'd0, res_sign, res_mag, ovf}, 32'd0);
    rst_ni = 1'b1;

    run("R1 plain add", 0, 123, 0, 456, 0);
    run("R1 max no ovf", 0, 500, 0, 499, 0);
    run("R2 sub example", 0, 500, 0, 155, 1);
    run("R2 sub to neg", 0, 155, 0, 500, 1);
    run("R3 mixed neg wins", 0, 12, 1, 340, 0);
    run("R3 mixed pos wins", 1, 12, 0, 340, 0);
    run("R3 both neg", 1, 250, 1, 250, 0);
    run("R4 x minus x", 0, 777, 0, 777, 1);
    run("R4 neg zero pair", 1, 0, 1, 0, 0);
    run("R4 neg zero sub", 0, 0, 0, 0, 1);
    run("R4 neg x plus x", 1, 45, 0, 45, 0);
    run("R5 carry chain", 0, 199, 0, 1, 0);
    run("R5 carry 999", 0, 989, 0, 9, 0);
    run("R6 pos ovf", 0, 999, 0, 1, 0);
    run("R6 neg 1000", 1, 999, 1, 1, 0);
    run("R6 neg edge ok", 1, 500, 1, 499, 0);
    run("R6 extreme", 1, 999, 0, 999, 1);
    run("R7 sub neg", 0, 300, 1, 400, 1);
    run("R7 sub neg ovf", 0, 600, 1, 400, 1);
    run("R8 mixed extreme", 0, 999, 1, 999, 0);
    run("R8 neg zero mixed", 1, 0, 1, 999, 0);
    run("R9 digit order", 0, 1, 0, 10, 0);
    run("R9 digit order hi", 0, 100, 0, 0, 0);

    for (int i = 0; i < 600; i++)
      run("R1 R2 R3 random", int'($urandom_range(1, 0)), int'($urandom_range(999, 0)),
          int'($urandom_range(1, 0)), int'($urandom_range(999, 0)),
          int'($urandom_range(1, 0)));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule